// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a small 16-bit CPU and turns its exception requests into one vector address. The requests come from several sources: three reset causes, an unimplemented-opcode trap, a software-interrupt or debug request, one request masked by the CPU's X bit, and a bank of requests masked by its I bit. When the CPU raises its vector-request strobe, the controller ranks every source that is pending and enabled in that cycle. On the next clock it presents the vector of the winner, together with a valid flag.

Each tier has a fixed rank. Resets come first, then the opcode trap, then the software/debug request, then the X-masked request, and last the I-masked bank in fixed index order. Reset vectors always sit in the top page (upper byte 0xFF). Every other vector takes its upper byte from a vector base register that software can write. If nothing enabled is pending when the strobe arrives, for example because a request dropped before it was taken, the controller returns a spurious vector at offset 0x80 from the base. The I-bank size `NUM_IRQ` may range from 1 to 57, so that its vectors stay above the spurious slot.

Top module: `intvec_ctrl`

## Requirements
- R1: One clock edge after a cycle with `vec_req`=1, `vec_valid` is 1 and `vec_addr` holds the selected vector. After a cycle with `vec_req`=0, `vec_valid` is 0.
- R2: Reset-cause bits select vectors that ignore the base register and both masks, and outrank all other sources. Bit 0 (pin or low-voltage reset) gives 0xFFFE. Bit 1 (clock fault) gives 0xFFFC. Bit 2 (watchdog) gives 0xFFFA. Among the reset bits, bit 0 ranks highest and bit 2 lowest.
- R3: The vector base register is loaded from `base_wdata` in any cycle with `base_we`=1. It supplies bits 15:8 of every non-reset vector. A request made in the same cycle as a write still uses the old value.
- R4: `unimpl`=1 gives base:0xF8 whatever the masks are, and outranks every non-reset source.
- R5: `swi` or `dbg` (either one, or both) gives base:0xF6 whatever the masks are, and outranks the X request and the I bank.
- R6: `x_req` counts only when `x_mask`=0, and then gives base:0xF4, ranking above the I bank. When `x_mask`=1 it has no effect.
- R7: `irq_req[n]` counts only when `i_mask`=0, and gives base:(0xF2 − 2·n). The lowest pending index wins.
- R8: When no enabled source is pending at the strobe, the result is the spurious vector base:0x80.
- R9: In reset, `vec_valid` and `vec_addr` are 0, and the base register returns to 0xFF, so a request with nothing pending yields 0xFF80.
- R10: Bit 0 of every produced vector is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_req | input | 1 | Vector-request strobe from the CPU |
| rst_cause | input | 3 | Reset causes: bit0 pin/low-voltage, bit1 clock fault, bit2 watchdog |
| unimpl | input | 1 | Unimplemented-opcode trap |
| swi | input | 1 | Software interrupt |
| dbg | input | 1 | Debug request, shares the software-interrupt vector |
| x_req | input | 1 | X-bit maskable request |
| x_mask | input | 1 | CPU X bit, 1 blocks `x_req` |
| irq_req | input | NUM_IRQ | I-bit maskable requests, index 0 highest |
| i_mask | input | 1 | CPU I bit, 1 blocks `irq_req` |
| base_we | input | 1 | Write strobe for the vector base register |
| base_wdata | input | 8 | New vector base value |
| vec_valid | output | 1 | Vector output valid |
| vec_addr | output | 16 | Vector address |

## Verification
Every vector is due on the first rising edge after the cycle that carries the strobe. A base write takes effect from that same edge onward, so it is seen only by requests made in later cycles. The driver changes inputs 2 ns after a rising edge and pushes the expected address into a queue at that moment. The monitor samples on the falling edge, half a cycle after the output edge, and pops one entry for each cycle in which `vec_valid` is high. A valid result with an empty queue counts as a failure, and so do entries left unconsumed at the end. The stimulus covers every pairing of tiers, every I-bank pair, all four mask combinations, back-to-back strobes and a pseudo-random sweep.

// File: rtl/intvec_pkg.sv
// Package: shared widths, vector offsets and offset helpers for the
// interrupt vector controller. Assumes a 16-bit address made of an
// 8-bit page (upper byte) and an 8-bit word-aligned offset.
package intvec_pkg;

    localparam int ADDR_W   = 16;
    localparam int PAGE_W   = 8;
    localparam int NUM_RST  = 3;

    localparam logic [PAGE_W-1:0] RESET_PAGE = 8'hFF;
    localparam logic [PAGE_W-1:0] BASE_INIT  = 8'hFF;

    localparam logic [7:0] OFF_RST0   = 8'hFE;
    localparam logic [7:0] OFF_UNIMPL = 8'hF8;
    localparam logic [7:0] OFF_SWI    = 8'hF6;
    localparam logic [7:0] OFF_XREQ   = 8'hF4;
    localparam logic [7:0] OFF_IRQ0   = 8'hF2;
    localparam logic [7:0] OFF_SPUR   = 8'h80;

    // Tier that won arbitration, in descending rank.
    typedef enum logic [2:0] {
        TIER_RESET,
        TIER_UNIMPL,
        TIER_SWI,
        TIER_XREQ,
        TIER_IRQ,
        TIER_SPUR
    } tier_e;

    // Offset of the reset vector for reset cause k.
    function automatic logic [7:0] rst_offset(input int unsigned k);
        return OFF_RST0 - 8'(2 * k);
    endfunction

    // Offset of the vector for I-bank entry n.
    function automatic logic [7:0] irq_offset(input int unsigned n);
        return OFF_IRQ0 - 8'(2 * n);
    endfunction

endpackage

// File: rtl/ivec_base_reg.sv
// Module: vector base register. Holds the upper address byte for all
// non-reset vectors. Assumes a synchronous active-low reset; a write
// becomes visible on the edge that captures it.
module ivec_base_reg
    import intvec_pkg::*;
#(
    parameter logic [PAGE_W-1:0] INIT = BASE_INIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] base_q
);

    // Load on write strobe, return to INIT in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= INIT;
        else if (we)
            base_q <= wdata;
    end

endmodule

// File: rtl/ivec_prio_enc.sv
// Module: fixed-priority encoder, lowest set index wins. Purely
// combinational. Assumes N >= 1; the index width is at least one bit.
module ivec_prio_enc #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest set index is the last assignment.
    always_comb begin
        hit = |req;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k])
                idx = IW'(k);
        end
    end

endmodule

// File: rtl/ivec_select.sv
// Module: tier arbiter. Ranks reset, trap, software/debug, X-masked and
// I-masked sources, applies the masks, and forms the next vector
// address. Combinational; assumes masked requests are already stable
// in the strobe cycle.
module ivec_select
    import intvec_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int IRQ_IW  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    parameter int RST_IW  = $clog2(NUM_RST)
) (
    input  logic [NUM_RST-1:0] rst_cause,
    input  logic               unimpl,
    input  logic               swi,
    input  logic               dbg,
    input  logic               x_req,
    input  logic               x_mask,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               i_mask,
    input  logic [PAGE_W-1:0]  base_q,
    output tier_e              tier,
    output logic [ADDR_W-1:0]  next_addr
);

    logic [NUM_IRQ-1:0] irq_live;
    logic               irq_hit;
    logic [IRQ_IW-1:0]  irq_idx;
    logic               rst_hit;
    logic [RST_IW-1:0]  rst_idx;
    logic [7:0]         irq_off_tab [NUM_IRQ];
    logic [7:0]         rst_off_tab [NUM_RST];

    // Gate every I-bank line with the I mask.
    genvar g;
    generate
        for (g = 0; g < NUM_IRQ; g++) begin : g_irq
            assign irq_live[g]    = irq_req[g] & ~i_mask;
            assign irq_off_tab[g] = irq_offset(g);
        end
        for (g = 0; g < NUM_RST; g++) begin : g_rst
            assign rst_off_tab[g] = rst_offset(g);
        end
    endgenerate

    ivec_prio_enc #(.N(NUM_RST), .IW(RST_IW)) u_rst_enc (
        .req (rst_cause),
        .hit (rst_hit),
        .idx (rst_idx)
    );

    ivec_prio_enc #(.N(NUM_IRQ), .IW(IRQ_IW)) u_irq_enc (
        .req (irq_live),
        .hit (irq_hit),
        .idx (irq_idx)
    );

    // Pick the winning tier in fixed rank order.
    always_comb begin
        if (rst_hit)
            tier = TIER_RESET;
        else if (unimpl)
            tier = TIER_UNIMPL;
        else if (swi || dbg)
            tier = TIER_SWI;
        else if (x_req && !x_mask)
            tier = TIER_XREQ;
        else if (irq_hit)
            tier = TIER_IRQ;
        else
            tier = TIER_SPUR;
    end

    // Form page and offset for the winning tier.
    always_comb begin
        unique case (tier)
            TIER_RESET:  next_addr = {RESET_PAGE, rst_off_tab[rst_idx]};
            TIER_UNIMPL: next_addr = {base_q, OFF_UNIMPL};
            TIER_SWI:    next_addr = {base_q, OFF_SWI};
            TIER_XREQ:   next_addr = {base_q, OFF_XREQ};
            TIER_IRQ:    next_addr = {base_q, irq_off_tab[irq_idx]};
            default:     next_addr = {base_q, OFF_SPUR};
        endcase
    end

endmodule

// File: rtl/intvec_ctrl.sv
// Module: top of the interrupt vector controller. Registers the
// arbitrated vector one clock after the request strobe. Assumes
// NUM_IRQ between 1 and 57, so I-bank vectors stay above the spurious
// slot, and a synchronous active-low reset.
module intvec_ctrl
    import intvec_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      vec_req,
    input  logic [intvec_pkg::NUM_RST-1:0] rst_cause,
    input  logic                      unimpl,
    input  logic                      swi,
    input  logic                      dbg,
    input  logic                      x_req,
    input  logic                      x_mask,
    input  logic [NUM_IRQ-1:0]        irq_req,
    input  logic                      i_mask,
    input  logic                      base_we,
    input  logic [intvec_pkg::PAGE_W-1:0] base_wdata,
    output logic                      vec_valid,
    output logic [intvec_pkg::ADDR_W-1:0] vec_addr
);

    logic [PAGE_W-1:0] base_q;
    logic [ADDR_W-1:0] next_addr;
    tier_e             tier;

    ivec_base_reg #(.INIT(BASE_INIT)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (base_we),
        .wdata  (base_wdata),
        .base_q (base_q)
    );

    ivec_select #(.NUM_IRQ(NUM_IRQ)) u_sel (
        .rst_cause (rst_cause),
        .unimpl    (unimpl),
        .swi       (swi),
        .dbg       (dbg),
        .x_req     (x_req),
        .x_mask    (x_mask),
        .irq_req   (irq_req),
        .i_mask    (i_mask),
        .base_q    (base_q),
        .tier      (tier),
        .next_addr (next_addr)
    );

    // Capture the vector on a strobe; valid lasts one cycle per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_addr  <= '0;
        end else begin
            vec_valid <= vec_req;
            if (vec_req)
                vec_addr <= next_addr;
        end
    end

endmodule

// File: rtl/intvec_ctrl_chk.sv
// Module: assertion checker for intvec_ctrl, attached with bind.
// Observes ports and the base register; drives nothing.
module intvec_ctrl_chk #(
    parameter int NUM_IRQ = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vec_req,
    input logic [2:0]         rst_cause,
    input logic               unimpl,
    input logic               swi,
    input logic               dbg,
    input logic               x_req,
    input logic               x_mask,
    input logic [NUM_IRQ-1:0] irq_req,
    input logic               i_mask,
    input logic [7:0]         base_q,
    input logic               vec_valid,
    input logic [15:0]        vec_addr
);

    logic non_rst;
    logic none_above_x;
    assign non_rst      = (rst_cause == 3'b000);
    assign none_above_x = non_rst && !unimpl && !swi && !dbg;

    // R1: strobe yields valid on the next edge
    a_r1_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> vec_valid);

    // R1: no strobe, no valid
    a_r1_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_req |=> !vec_valid);

    // R10: vectors are word aligned
    a_r10_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr[0] == 1'b0));

    // R2: pin/low-voltage reset wins everything
    a_r2_pin_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && rst_cause[0]) |=> (vec_addr == 16'hFFFE));

    // R2: any reset cause lands in the top page
    a_r2_reset_page: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !non_rst) |=> (vec_addr[15:8] == 8'hFF));

    // R3: non-reset vectors use the base value seen at the strobe
    a_r3_base_page: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && non_rst) |=> (vec_addr[15:8] == $past(base_q)));

    // R4: trap ignores masks and outranks the rest
    a_r4_unimpl: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && non_rst && unimpl) |=> (vec_addr[7:0] == 8'hF8));

    // R6: unmasked X request outranks the I bank
    a_r6_xreq: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && none_above_x && x_req && !x_mask) |=> (vec_addr[7:0] == 8'hF4));

    // R8: nothing enabled pending gives the spurious slot
    a_r8_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && none_above_x && !(x_req && !x_mask) && (i_mask || irq_req == '0))
        |=> (vec_addr[7:0] == 8'h80));

endmodule

bind intvec_ctrl intvec_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_req   (vec_req),
    .rst_cause (rst_cause),
    .unimpl    (unimpl),
    .swi       (swi),
    .dbg       (dbg),
    .x_req     (x_req),
    .x_mask    (x_mask),
    .irq_req   (irq_req),
    .i_mask    (i_mask),
    .base_q    (base_q),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr)
);

// File: tb/sim_intvec_ctrl.sv
module sim_intvec_ctrl;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vec_req = 1'b0;
    logic [2:0]   rst_cause = '0;
    logic         unimpl = 1'b0, swi = 1'b0, dbg = 1'b0;
    logic         x_req = 1'b0, x_mask = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic         i_mask = 1'b0;
    logic         base_we = 1'b0;
    logic [7:0]   base_wdata = '0;
    logic         vec_valid;
    logic [15:0]  vec_addr;

    int total = 0;
    int bad   = 0;
    logic [7:0] base_m = 8'hFF;

    typedef struct {
        logic [15:0] addr;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    intvec_ctrl #(.NUM_IRQ(N)) u0 (
        .clk(clk), .rst_n(rst_n), .vec_req(vec_req), .rst_cause(rst_cause),
        .unimpl(unimpl), .swi(swi), .dbg(dbg), .x_req(x_req), .x_mask(x_mask),
        .irq_req(irq_req), .i_mask(i_mask), .base_we(base_we),
        .base_wdata(base_wdata), .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    // Expected vector from the requirements.
    function automatic logic [15:0] model(input logic [2:0] rc, input logic un,
        input logic sw, input logic db, input logic xr, input logic xm,
        input logic [N-1:0] ir, input logic im, input logic [7:0] b);
        if (rc[0]) return 16'hFFFE;
        if (rc[1]) return 16'hFFFC;
        if (rc[2]) return 16'hFFFA;
        if (un) return {b, 8'hF8};
        if (sw || db) return {b, 8'hF6};
        if (xr && !xm) return {b, 8'hF4};
        if (!im)
            for (int k = 0; k < N; k++)
                if (ir[k]) return {b, 8'hF2 - 8'(2 * k)};
        return {b, 8'h80};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one strobe cycle and push its expected vector.
    task automatic req(input string tag, input logic [2:0] rc, input logic un,
        input logic sw, input logic db, input logic xr, input logic xm,
        input logic [N-1:0] ir, input logic im,
        input logic we = 1'b0, input logic [7:0] wd = 8'h00);
        exp_t e;
        rst_cause = rc; unimpl = un; swi = sw; dbg = db;
        x_req = xr; x_mask = xm; irq_req = ir; i_mask = im;
        vec_req = 1'b1; base_we = we; base_wdata = wd;
        e.addr = model(rc, un, sw, db, xr, xm, ir, im, base_m);
        e.tag  = tag;
        sb.push_back(e);
        if (we) base_m = wd;
        @(posedge clk); #2;
    endtask

    task automatic idle(input int n = 1);
        vec_req = 1'b0; base_we = 1'b0;
        rst_cause = '0; unimpl = 0; swi = 0; dbg = 0; x_req = 0; irq_req = '0;
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr_base(input logic [7:0] v);
        vec_req = 1'b0; base_we = 1'b1; base_wdata = v; base_m = v;
        @(posedge clk); #2;
        base_we = 1'b0;
    endtask

    // Monitor: compare each valid vector with the scoreboard.
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R9 valid in reset", {15'd0, vec_valid}, 16'd0);
            chk("R9 addr in reset", vec_addr, 16'd0);
        end else if (vec_valid) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R1: actual=valid expected=idle (addr %h)", vec_addr);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, vec_addr, e.addr);
                chk("R10 aligned", {15'd0, vec_addr[0]}, 16'd0);
            end
        end
    end

    // Watchdog.
    initial begin
        #3000000;
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;

        // R9 / R8: nothing pending after reset
        req("R9 spurious after reset", 3'b000, 0,0,0,0,0,'0,0); idle();
        req("R8 masked I only", 3'b000, 0,0,0,0,0,8'h01,1); idle();

        // R2 resets, with a non-default base and all others pending
        wr_base(8'h12);
        req("R2 pin", 3'b001, 1,1,1,1,0,8'hFF,0); idle();
        req("R2 clock", 3'b010, 1,1,1,1,0,8'hFF,0); idle();
        req("R2 watchdog", 3'b100, 1,1,1,1,1,8'hFF,1); idle();
        req("R2 pin over all", 3'b111, 0,0,0,0,0,'0,0); idle();
        req("R2 clock over watchdog", 3'b110, 0,0,0,0,0,'0,0); idle();

        // R4 / R5 / R6 tiers and ties
        wr_base(8'h40);
        req("R4 unimpl masked", 3'b000, 1,1,1,1,1,8'hFF,1); idle();
        req("R4 unimpl over x", 3'b000, 1,0,0,1,0,8'hFF,0); idle();
        req("R5 swi", 3'b000, 0,1,0,1,0,8'hFF,0); idle();
        req("R5 dbg masked", 3'b000, 0,0,1,1,1,8'hFF,1); idle();
        req("R5 both", 3'b000, 0,1,1,0,0,'0,0); idle();
        req("R6 x over I", 3'b000, 0,0,0,1,0,8'h01,0); idle();
        req("R6 x masked falls to I", 3'b000, 0,0,0,1,1,8'h04,0); idle();
        req("R6 x masked alone", 3'b000, 0,0,0,1,1,'0,0); idle();

        // R7 each line, every pair, mask combos
        for (int k = 0; k < N; k++) begin
            req("R7 single", 3'b000, 0,0,0,0,0,8'(1 << k),0); idle();
        end
        for (int a = 0; a < N; a++)
            for (int b = a + 1; b < N; b++)
                req("R7 pair", 3'b000, 0,0,0,0,0,8'((1 << a) | (1 << b)),0);
        idle();
        for (int m = 0; m < 4; m++) begin
            req("R6 R7 mask combo x+I", 3'b000, 0,0,0,1,m[0],8'h30,m[1]);
            req("R8 mask combo x only", 3'b000, 0,0,0,1,m[0],'0,m[1]);
            req("R7 mask combo I only", 3'b000, 0,0,0,0,m[0],8'h80,m[1]);
        end
        idle();

        // R3 write in the strobe cycle: old base, then new
        req("R3 write same cycle", 3'b000, 0,0,0,0,0,8'h02,0, 1'b1, 8'hA5);
        req("R3 new base next", 3'b000, 0,0,0,0,0,8'h02,0);
        idle();
        wr_base(8'h00);
        req("R3 base zero", 3'b000, 0,0,0,0,0,'0,0); idle();

        // Pseudo-random sweep, back to back
        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            req("R1 R7 sweep", (lf[15:13] == 3'b000) ? lf[2:0] : 3'b000,
                lf[3] & lf[4] & lf[5], lf[6] & lf[7], lf[8] & lf[9] & lf[3],
                lf[10], lf[11], lf[7:0] & {lf[12], lf[14:8]}, lf[12],
                (lf[15:12] == 4'hF), lf[11:4]);
            if (lf[0]) idle();
        end
        idle(3);

        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R1: actual=%0d pending expected=0", sb.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule